// File: doc/BRIEF.md
# Single-Bit Test Branch Evaluator

This block decodes and evaluates a conditional branch whose condition is one bit of a 64-bit register. The instruction word selects a bit index from 0 to 63 and says whether the branch should be taken when that bit is 1 or when it is 0. The block also computes the PC-relative target. The register file is read through a select output, and the fetched value comes back on the source operand input. A flag tells the block that the current instruction sits in the shadow of an earlier branch.

All results are registered with one cycle of latency. When the instruction decodes cleanly, the block asks the sequencer to treat the next instruction as a 32-bit delay slot. If the branch itself sits in a delay or forbidden slot, no branch is evaluated and a reserved-instruction exception is flagged instead. The surrounding pipeline owns PC sequencing and exception delivery.

Top module: `bitbranch_eval`

## Requirements
- R1: The `hit` output is 1, one cycle after an instruction word with bits [31:30]=2'b11 and bits [27:26]=2'b10 is presented. For any other word, `hit` is 0 one cycle later.
- R2: The tested bit index is the 5-bit field in bits [20:16], with 32 added when bit 28 is 1. This lets the upper half of the source operand (bits 32 to 63) be tested.
- R3: Bit 29 of the word selects the sense of the test. With bit 29 = 1, `take` is 1 exactly when the tested bit is 1. With bit 29 = 0, `take` is 1 exactly when the tested bit is 0.
- R4: For a decoded branch outside a slot, `target` equals PC + 4 + (bits [15:0] sign-extended and multiplied by 4).
- R5: The target arithmetic is 64 bits wide and wraps modulo 2^64, in both the forward and the backward direction.
- R6: A decoded branch outside a slot sets `slot_req` to 1, requesting a 32-bit delay slot.
- R7: A decoded branch while `in_slot` is 1 sets `hit` and `ri_exc` to 1 and holds `take`, `slot_req` and `target` at 0.
- R8: A non-matching word drives `take`, `slot_req`, `ri_exc` and `target` to 0.
- R9: Every registered output reflects the inputs sampled at the previous rising clock edge.
- R10: A synchronous active-high reset clears `hit`, `take`, `slot_req`, `ri_exc` and `target`.
- R11: `reg_sel` combinationally presents bits [25:21] of the instruction word as the register-file read select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word |
| pc | input | 64 | Address of the instruction |
| src | input | 64 | Source operand read from the register file |
| in_slot | input | 1 | Instruction sits in a delay or forbidden slot |
| reg_sel | output | 5 | Register-file read select |
| hit | output | 1 | Registered: the word decoded as a bit-test branch |
| take | output | 1 | Registered: the branch is taken |
| target | output | 64 | Registered: branch target address |
| slot_req | output | 1 | Registered: the next instruction is a 32-bit delay slot |
| ri_exc | output | 1 | Registered: reserved-instruction exception |

## Verification
The bench builds the block with its defaults: a 64-bit operand and PC, and a 16-bit offset. At these values the bit-28 "+32" path can reach every bit of the operand, so tests of bits 0, 31, 32 and 63 each land on a distinct half and edge. A 64-bit PC also makes the wrap in both directions testable: a PC near all-ones with a forward offset, and a small PC with the most negative offset. Random words are biased so that about half of them match the decode pattern, while the rest exercise the non-matching path.

// File: rtl/bitbranch_eval.sv
module bitbranch_eval #(
  parameter int XLEN = 64,
  parameter int OFFW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] src,
  input  logic            in_slot,
  output logic [4:0]      reg_sel,
  output logic            hit,
  output logic            take,
  output logic [XLEN-1:0] target,
  output logic            slot_req,
  output logic            ri_exc
);
  localparam int IDXW = $clog2(XLEN);
  localparam int EXTW = XLEN - OFFW - 2;

  logic            is_br;
  logic            ok;
  logic [IDXW-1:0] idx;
  logic            tbit;
  logic            cond;
  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] tgt_n;

  assign reg_sel = instr[25:21];
  assign is_br   = (instr[31:30] == 2'b11) && (instr[27:26] == 2'b10);
  assign ok      = is_br && !in_slot;
  assign idx     = IDXW'({instr[28], instr[20:16]});
  assign tbit    = src[idx];
  assign cond    = instr[29] ? tbit : !tbit;
  assign disp    = {{EXTW{instr[OFFW-1]}}, instr[OFFW-1:0], 2'b00};
  assign tgt_n   = pc + XLEN'(4) + disp;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit      <= 1'b0;
      take     <= 1'b0;
      target   <= '0;
      slot_req <= 1'b0;
      ri_exc   <= 1'b0;
    end else begin
      hit      <= is_br;
      take     <= ok && cond;
      target   <= ok ? tgt_n : '0;
      slot_req <= ok;
      ri_exc   <= is_br && in_slot;
    end
  end

  a_r1_decode: assert property (@(posedge clk) disable iff (rst)
    (instr[31:30] == 2'b11 && instr[27:26] == 2'b10) |=> hit);

  a_r6_slot_request: assert property (@(posedge clk) disable iff (rst)
    (hit && !ri_exc) |-> slot_req);

  a_r7_exc_blocks: assert property (@(posedge clk) disable iff (rst)
    ri_exc |-> (hit && !take && !slot_req && target == '0));

  a_r7_exc_source: assert property (@(posedge clk) disable iff (rst)
    (instr[31:30] == 2'b11 && instr[27:26] == 2'b10 && in_slot) |=> ri_exc);

  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (!take && !slot_req && !ri_exc && target == '0));

  a_r9_take_stable: assert property (@(posedge clk) disable iff (rst)
    ($stable(instr) && $stable(src) && $stable(in_slot) && hit) |=> $stable(take));
endmodule

// File: tb/bitbranch_eval_test.sv
module bitbranch_eval_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instr;
  logic [63:0] pc;
  logic [63:0] src;
  logic        in_slot;
  logic [4:0]  reg_sel;
  logic        hit, take, slot_req, ri_exc;
  logic [63:0] target;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  bitbranch_eval uut (
    .clk(clk), .rst(rst), .instr(instr), .pc(pc), .src(src), .in_slot(in_slot),
    .reg_sel(reg_sel), .hit(hit), .take(take), .target(target),
    .slot_req(slot_req), .ri_exc(ri_exc)
  );

  function automatic logic e_hit(logic [31:0] w);
    return w[31] && w[30] && w[27] && !w[26];
  endfunction

  function automatic logic e_take(logic [31:0] w, logic [63:0] s, logic sl);
    int b = int'(w[20:16]) + (w[28] ? 32 : 0);
    if (!e_hit(w) || sl) return 1'b0;
    return w[29] ? s[b] : !s[b];
  endfunction

  function automatic logic [63:0] e_tgt(logic [31:0] w, logic [63:0] p, logic sl);
    logic signed [63:0] o = 64'(signed'(w[15:0]));
    if (!e_hit(w) || sl) return 64'd0;
    return p + 64'd4 + 64'(o * 4);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, logic [63:0] p, logic [63:0] s, logic sl, string tag);
    @(negedge clk);
    instr = w; pc = p; src = s; in_slot = sl;
    chk({tag, " R11 reg_sel"}, 64'(reg_sel), 64'(w[25:21]));
    @(negedge clk);
    chk({tag, " R1 R9 hit"}, 64'(hit), 64'(e_hit(w)));
    chk({tag, " R2 R3 take"}, 64'(take), 64'(e_take(w, s, sl)));
    chk({tag, " R4 R5 target"}, target, e_tgt(w, p, sl));
    chk({tag, " R6 slot_req"}, 64'(slot_req), 64'(e_hit(w) && !sl));
    chk({tag, " R7 R8 ri_exc"}, 64'(ri_exc), 64'(e_hit(w) && sl));
  endtask

  function automatic logic [31:0] mk(logic set, logic hi, logic [4:0] p, logic [15:0] off);
    return {2'b11, set, hi, 2'b10, 5'd7, p, off};
  endfunction

  task automatic chk_reset_state(string tag);
    chk({tag, " R10 hit"}, 64'(hit), 64'd0);
    chk({tag, " R10 take"}, 64'(take), 64'd0);
    chk({tag, " R10 target"}, target, 64'd0);
    chk({tag, " R10 slot_req"}, 64'(slot_req), 64'd0);
    chk({tag, " R10 ri_exc"}, 64'(ri_exc), 64'd0);
  endtask

  task automatic done();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      done();
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20240607));
    rst = 1'b1; instr = 32'h0; pc = 64'h0; src = 64'h0; in_slot = 1'b0;
    repeat (3) @(negedge clk);
    chk_reset_state("reset");
    rst = 1'b0;

    apply(mk(1'b1, 1'b0, 5'd0, 16'd8), 64'h1000, 64'h1, 1'b0, "R3 set bit0 taken");
    apply(mk(1'b1, 1'b0, 5'd0, 16'd8), 64'h1000, 64'h2, 1'b0, "R3 set bit0 not taken");
    apply(mk(1'b0, 1'b0, 5'd31, 16'd1), 64'h2000, 64'h7FFF_FFFF, 1'b0, "R2 clear bit31");
    apply(mk(1'b1, 1'b1, 5'd0, 16'd1), 64'h2000, 64'h1_0000_0000, 1'b0, "R2 set bit32");
    apply(mk(1'b1, 1'b1, 5'd31, 16'd1), 64'h2000, 64'h8000_0000_0000_0000, 1'b0, "R2 set bit63");
    apply(mk(1'b0, 1'b1, 5'd31, 16'd1), 64'h2000, 64'h8000_0000_0000_0000, 1'b0, "R2 clear bit63");
    apply(mk(1'b1, 1'b0, 5'd3, 16'hFFFF), 64'h4000, 64'h8, 1'b0, "R4 backward");
    apply(mk(1'b1, 1'b0, 5'd3, 16'h0010), 64'hFFFF_FFFF_FFFF_FFF0, 64'h8, 1'b0, "R5 forward wrap");
    apply(mk(1'b1, 1'b0, 5'd3, 16'h8000), 64'h10, 64'h8, 1'b0, "R5 backward wrap");
    apply(mk(1'b1, 1'b0, 5'd3, 16'h0004), 64'h4000, 64'h8, 1'b1, "R7 in slot");
    apply(32'hCC00_0004, 64'h4000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R8 no match 27:26");
    apply(32'h8800_0004, 64'h4000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R8 no match 31:30");

    apply(mk(1'b1, 1'b0, 5'd0, 16'd8), 64'h1000, 64'h1, 1'b0, "R10 pre");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); chk_reset_state("mid reset");
    rst = 1'b0;

    for (int i = 0; i < 400; i++) begin
      w = $urandom;
      if ($urandom_range(1, 0) == 1) begin
        w[31:30] = 2'b11; w[27:26] = 2'b10;
      end
      apply(w, {$urandom, $urandom}, {$urandom, $urandom}, ($urandom_range(3, 0) == 0), "random");
    end
    done();
  end
endmodule